// File: doc/BRIEF.md
# One-Time-Programmable Word Store Emulator

This block is a synthesizable, clock-cycle model of a 16-bit-wide one-time-programmable read-only memory. It watches a chip-select, an output-enable, a program strobe and two flags. The first flag says that the programming supply is present. The second says that address line 9 is held at identification voltage. From these pins it derives one operating mode each cycle: read, output off, standby, program, program-verify, program-inhibit or identification.

Programming merges the data bus into the addressed word with a bitwise AND. Bits can therefore be cleared but never set again, which is what makes the store one-time programmable. After reset the whole array is erased, so every bit reads as 1.

The output side has three parts: a data word, a drive indicator that stands in for a tri-state buffer, and a data-valid flag. Address-to-data, select-to-data and enable-to-data delays are modelled as clock-cycle counts, and so is the time the output takes to float. The address bus is always 16 bits wide. The depth of the stored array is set by a parameter, so a small array can be used in simulation. A larger address folds onto the array through its low bits.

Top module: `otp_word_store`

## Requirements
- R1: While reset is asserted and on the first edge after it, `q_drive`, `q_valid` and `q` are all 0. Every stored word reads 0xFFFF after reset.
- R2: With `sel_n`=0, `oe_n`=0, `vpp_on`=0 and no identification match, the block drives the word whose index is the low `DEPTH_W` bits of `addr`. Higher address bits are ignored, so 0x0105 reads the same word as 0x0005 when `DEPTH_W`=8.
- R3: When the block leaves a driving mode (read, verify, identification), `q_valid` is 0 from the next edge. `q_drive` falls on the `FLOAT_CYC`-th edge, counting the first edge that samples the change as edge 1. This holds when the cause is `oe_n` going high and when it is `sel_n` going high.
- R4: With `vpp_on`=1, `sel_n`=0, `oe_n`=1 and `pgm_n`=0, each edge replaces the addressed word with (word AND `din`). A 0 bit never returns to 1.
- R5: With `vpp_on`=1, `sel_n`=0, `oe_n`=0 and `pgm_n`=1 (verify), the stored word is driven.
- R6: With `vpp_on`=1 and `sel_n`=1 (inhibit), no word changes, whatever `pgm_n` and `din` are, and the output floats.
- R7: With `hv_a9`=1, `vpp_on`=0, `sel_n`=0, `oe_n`=0, `addr[0]` ignored, `addr[9]` ignored and every other address bit 0, the block returns 0x001E when `addr[0]`=0 and 0x00F1 when `addr[0]`=1. If any other address bit is 1, it performs a normal array read.
- R8: After a change of `addr` or `hv_a9` in a driving mode, `q_valid` is 0 until the `ACC_CYC`-th edge, counting the first edge that samples the change as edge 1. On that edge it rises with the new word.
- R9: After `sel_n` falls with `oe_n` already low, `q_valid` rises on the `SEL_CYC`-th edge, counted the same way.
- R10: After `oe_n` falls with `sel_n` low and settled, `q_valid` rises on the `OE_CYC`-th edge, counted the same way.
- R11: While `q_valid` is 0, `q` holds the last valid word. `q_valid`=1 only while `q_drive`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_on | input | 1 | Programming supply present |
| hv_a9 | input | 1 | Address line 9 at identification voltage |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Data to program |
| q | output | DATA_W | Output word (hold value while not valid) |
| q_drive | output | 1 | Output would be driven (not floating) |
| q_valid | output | 1 | Output word is settled and valid |

## Verification
Two things can fall in the same cycle: an address change and a mode change. Stepping from verify to read keeps the output valid, but moving the address in a read restarts the access count. In that cycle the output must keep showing the previous word and must drop its valid flag. The bench provokes this by moving the address right after a valid read. It checks that `q` still carries the old word one edge later, and that the new word appears on exactly the access-count edge. A second case is a program pulse that overlaps the output float. There, the float count must run out on its own schedule while the array is being written, and the later verify must show the AND of both program patterns.

// File: rtl/otp_pkg.sv
// Package: shared mode encoding and identification codes for the
// one-time-programmable word store emulator.
// Assumes: 16-bit identification codes; narrower data words truncate them.
package otp_pkg;

    typedef enum logic [2:0] {
        M_STANDBY = 3'd0,
        M_READ    = 3'd1,
        M_OUT_OFF = 3'd2,
        M_PROG    = 3'd3,
        M_VERIFY  = 3'd4,
        M_INHIBIT = 3'd5,
        M_IDENT   = 3'd6
    } op_mode_t;

    localparam logic [15:0] MAKER_CODE = 16'h001E;
    localparam logic [15:0] PART_CODE  = 16'h00F1;

    // True for the modes that place a word on the output.
    function automatic logic mode_drives(input op_mode_t m);
        return (m == M_READ) || (m == M_VERIFY) || (m == M_IDENT);
    endfunction

endpackage

// File: rtl/otp_mode_decode.sv
// Module: otp_mode_decode
// Turns the control pins into one operating mode, purely combinationally.
// Assumes: pins are synchronous to the clock; the identification match
// ignores address bit 0 (code select) and the high-voltage bit itself.
module otp_mode_decode
    import otp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int HV_BIT = 9
) (
    input  logic              sel_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              vpp_on,
    input  logic              hv_a9,
    input  logic [ADDR_W-1:0] addr,
    output op_mode_t          mode
);

    localparam logic [ADDR_W-1:0] ID_IGNORE = (ADDR_W'(1) << HV_BIT) | ADDR_W'(1);

    logic id_match;

    // Identification address: high voltage present, remaining bits low.
    always_comb begin
        id_match = hv_a9 && ((addr & ~ID_IGNORE) == '0);
    end

    // Mode table: select high first, then supply, then enables.
    always_comb begin
        if (sel_n) begin
            mode = vpp_on ? M_INHIBIT : M_STANDBY;
        end else if (!vpp_on) begin
            if (oe_n)          mode = M_OUT_OFF;
            else if (id_match) mode = M_IDENT;
            else               mode = M_READ;
        end else begin
            if (oe_n && !pgm_n)      mode = M_PROG;
            else if (!oe_n && pgm_n) mode = M_VERIFY;
            else                     mode = M_OUT_OFF;
        end
    end

endmodule

// File: rtl/otp_cell_array.sv
// Module: otp_cell_array
// Word array with clear-only writes: a write ANDs the bus into the word.
// Assumes: reset returns every word to the erased (all ones) state; read
// is combinational from the same address used for writing.
module otp_cell_array #(
    parameter int DATA_W  = 16,
    parameter int DEPTH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [DEPTH_W-1:0] addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata
);

    localparam int DEPTH = 1 << DEPTH_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Erase on reset; otherwise clear the bits that are 0 on the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
        end else if (we) begin
            cells[addr] <= cells[addr] & wdata;
        end
    end

    // Read port.
    always_comb begin
        rdata = cells[addr];
    end

    // R4
    program_only_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((cells[$past(addr)] & ~$past(rdata)) == '0));

endmodule

// File: rtl/otp_out_timer.sv
// Module: otp_out_timer
// Models access and float timing in clock cycles and presents the word.
// Assumes: every delay parameter is at least 1; a delay of N means the
// effect shows on the N-th edge counting the sampling edge as the first.
module otp_out_timer #(
    parameter int DATA_W    = 16,
    parameter int ACC_CYC   = 23,
    parameter int SEL_CYC   = 23,
    parameter int OE_CYC    = 8,
    parameter int FLOAT_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              oe_n,
    input  logic              addr_chg,
    input  logic              drv_in,
    input  logic [DATA_W-1:0] word_in,
    output logic [DATA_W-1:0] q,
    output logic              q_drive,
    output logic              q_valid
);

    localparam int MAX_AB  = (ACC_CYC > SEL_CYC) ? ACC_CYC : SEL_CYC;
    localparam int MAX_CD  = (OE_CYC > FLOAT_CYC) ? OE_CYC : FLOAT_CYC;
    localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0]  acc_cnt;
    logic [CNT_W-1:0]  sel_cnt;
    logic [CNT_W-1:0]  oe_cnt;
    logic [CNT_W-1:0]  flt_cnt;
    logic              drv_q;
    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] hold_q;

    // Saturating step down toward zero.
    function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c);
        return (c == '0) ? '0 : c - CNT_W'(1);
    endfunction

    // Access counters: reload on the triggering condition, then count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_cnt <= '0;
            sel_cnt <= CNT_W'(SEL_CYC);
            oe_cnt  <= CNT_W'(OE_CYC);
        end else begin
            acc_cnt <= addr_chg ? CNT_W'(ACC_CYC - 1) : step(acc_cnt);
            sel_cnt <= sel_n ? CNT_W'(SEL_CYC) : step(sel_cnt);
            oe_cnt  <= oe_n ? CNT_W'(OE_CYC) : step(oe_cnt);
        end
    end

    // Float counter: full while driving, runs out after the mode ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_cnt <= '0;
            drv_q   <= 1'b0;
        end else begin
            flt_cnt <= drv_in ? CNT_W'(FLOAT_CYC) : step(flt_cnt);
            drv_q   <= drv_in;
        end
    end

    // Word pipeline and hold register for the not-yet-valid window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            hold_q <= '0;
        end else begin
            word_q <= word_in;
            hold_q <= q;
        end
    end

    // Output: new word once all access counts have expired.
    always_comb begin
        q_valid = drv_q && (acc_cnt == '0) && (sel_cnt == '0) && (oe_cnt == '0);
        q_drive = (flt_cnt != '0);
        q       = q_valid ? word_q : hold_q;
    end

    // R11
    valid_needs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |-> q_drive);

    // R11
    hold_while_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |-> $stable(q));

    // R3
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_in |=> !q_valid);

    // R8
    addr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_chg |=> ((ACC_CYC == 1) || !q_valid));

endmodule

// File: rtl/otp_word_store.sv
// Module: otp_word_store (top)
// Cycle model of a one-time-programmable 16-bit word store: decodes the
// pin mode, programs by clearing bits, returns identification codes and
// times the output in clock cycles.
// Assumes: all pins synchronous to clk; array depth is 2**DEPTH_W words,
// addressed by the low DEPTH_W address bits.
module otp_word_store
    import otp_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int DEPTH_W   = 8,
    parameter int HV_BIT    = 9,
    parameter int ACC_CYC   = 23,
    parameter int SEL_CYC   = 23,
    parameter int OE_CYC    = 8,
    parameter int FLOAT_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              vpp_on,
    input  logic              hv_a9,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q,
    output logic              q_drive,
    output logic              q_valid
);

    op_mode_t          mode;
    logic [DATA_W-1:0] cell_word;
    logic [DATA_W-1:0] word_sel;
    logic [ADDR_W-1:0] addr_q;
    logic              hv_q;
    logic              addr_chg;

    otp_mode_decode #(
        .ADDR_W (ADDR_W),
        .HV_BIT (HV_BIT)
    ) u_decode (
        .sel_n  (sel_n),
        .oe_n   (oe_n),
        .pgm_n  (pgm_n),
        .vpp_on (vpp_on),
        .hv_a9  (hv_a9),
        .addr   (addr),
        .mode   (mode)
    );

    otp_cell_array #(
        .DATA_W  (DATA_W),
        .DEPTH_W (DEPTH_W)
    ) u_cells (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mode == M_PROG),
        .addr  (addr[DEPTH_W-1:0]),
        .wdata (din),
        .rdata (cell_word)
    );

    // Previous address and high-voltage flag, for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            hv_q   <= 1'b0;
        end else begin
            addr_q <= addr;
            hv_q   <= hv_a9;
        end
    end

    // Change detect and word source selection.
    always_comb begin
        addr_chg = (addr != addr_q) || (hv_a9 != hv_q);
        if (mode == M_IDENT) begin
            word_sel = addr[0] ? DATA_W'(PART_CODE) : DATA_W'(MAKER_CODE);
        end else begin
            word_sel = cell_word;
        end
    end

    otp_out_timer #(
        .DATA_W    (DATA_W),
        .ACC_CYC   (ACC_CYC),
        .SEL_CYC   (SEL_CYC),
        .OE_CYC    (OE_CYC),
        .FLOAT_CYC (FLOAT_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n    (sel_n),
        .oe_n     (oe_n),
        .addr_chg (addr_chg),
        .drv_in   (mode_drives(mode)),
        .word_in  (word_sel),
        .q        (q),
        .q_drive  (q_drive),
        .q_valid  (q_valid)
    );

endmodule

// File: tb/otp_word_store_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected output items with the cycle
// they are due; a negedge monitor pops and compares them.
module otp_word_store_bench;

    localparam int ACC = 23;
    localparam int SEL = 23;
    localparam int OEC = 8;
    localparam int FLT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp_on = 1'b0, hv_a9 = 1'b0;
    logic [15:0] addr = '0, din = '0;
    logic [15:0] q;
    logic        q_drive, q_valid;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        int          due;
        bit          chk_q;
        logic [15:0] exp_q;
        logic        exp_valid;
        logic        exp_drive;
        string       req;
    } exp_t;

    exp_t sb[$];

    otp_word_store u_otp_word_store (
        .clk (clk), .rst_n (rst_n), .sel_n (sel_n), .oe_n (oe_n), .pgm_n (pgm_n),
        .vpp_on (vpp_on), .hv_a9 (hv_a9), .addr (addr), .din (din),
        .q (q), .q_drive (q_drive), .q_valid (q_valid)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc++;

    // Monitor: compare every item due at this negedge.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                total++;
                if ((q_valid !== sb[i].exp_valid) || (q_drive !== sb[i].exp_drive) ||
                    (sb[i].chk_q && (q !== sb[i].exp_q))) begin
                    bad++;
                    $display("FAIL %s cyc=%0d actual q=%h valid=%b drive=%b expected q=%h valid=%b drive=%b",
                             sb[i].req, cyc, q, q_valid, q_drive,
                             sb[i].exp_q, sb[i].exp_valid, sb[i].exp_drive);
                end
                sb.delete(i);
            end
        end
    end

    // Queue an expectation a number of negedges after now.
    task automatic expect_at(input int off, input bit cq, input logic [15:0] eq,
                             input logic ev, input logic ed, input string r);
        exp_t e;
        e.due = cyc + off; e.chk_q = cq; e.exp_q = eq;
        e.exp_valid = ev; e.exp_drive = ed; e.req = r;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        expect_at(1, 1, 16'h0000, 0, 0, "R1 reset state");
        idle(3);

        // Read of an erased word, select and enable fall together
        sel_n = 0; oe_n = 0; addr = 16'h0005;
        expect_at(SEL - 1, 0, '0, 0, 1, "R9 not yet valid");
        expect_at(SEL, 1, 16'hFFFF, 1, 1, "R9 R1 erased word valid");
        idle(SEL + 3);

        // Program with 0xA5A5; output floats meanwhile
        vpp_on = 1; oe_n = 1; pgm_n = 0; din = 16'hA5A5;
        expect_at(1, 1, 16'hFFFF, 0, 1, "R11 hold after valid drop");
        expect_at(FLT - 1, 0, '0, 0, 1, "R3 still driving");
        expect_at(FLT, 0, '0, 0, 0, "R3 floated");
        idle(FLT + 2);

        // Verify
        pgm_n = 1; oe_n = 0;
        expect_at(OEC - 1, 0, '0, 0, 1, "R10 not yet valid");
        expect_at(OEC, 1, 16'hA5A5, 1, 1, "R5 R10 verify word");
        idle(OEC + 2);

        // Second program tries to set bits back
        oe_n = 1; pgm_n = 0; din = 16'h5AFF;
        idle(10);
        pgm_n = 1; oe_n = 0;
        expect_at(OEC, 1, 16'h00A5, 1, 1, "R4 clear-only program");
        idle(OEC + 2);

        // Inhibit: strobe active, select high
        sel_n = 1; oe_n = 1; pgm_n = 0; din = 16'h0000;
        expect_at(FLT + 1, 0, '0, 0, 0, "R6 float in inhibit");
        idle(FLT + 4);
        sel_n = 0; pgm_n = 1; oe_n = 0;
        expect_at(SEL - 1, 0, '0, 0, 1, "R9 not yet valid after inhibit");
        expect_at(SEL, 1, 16'h00A5, 1, 1, "R6 word unchanged");
        idle(SEL + 2);

        // Normal read, then address change restarts access
        vpp_on = 0;
        expect_at(2, 1, 16'h00A5, 1, 1, "R2 read word");
        idle(3);
        addr = 16'h0006;
        expect_at(1, 1, 16'h00A5, 0, 1, "R11 R8 old word held");
        expect_at(ACC - 1, 0, '0, 0, 1, "R8 not yet valid");
        expect_at(ACC, 1, 16'hFFFF, 1, 1, "R8 new word");
        idle(ACC + 2);

        // High address bits fold
        addr = 16'h0105;
        expect_at(ACC, 1, 16'h00A5, 1, 1, "R2 aliased address");
        idle(ACC + 2);

        // Identification codes
        hv_a9 = 1; addr = 16'h0000;
        expect_at(ACC, 1, 16'h001E, 1, 1, "R7 maker code");
        idle(ACC + 2);
        addr = 16'h0001;
        expect_at(ACC, 1, 16'h00F1, 1, 1, "R7 part code");
        idle(ACC + 2);
        addr = 16'h0205;
        expect_at(ACC, 1, 16'h00A5, 1, 1, "R7 no match reads array");
        idle(ACC + 2);

        // Output enable high then low
        oe_n = 1;
        expect_at(1, 1, 16'h00A5, 0, 1, "R3 valid drops on oe");
        expect_at(FLT - 1, 0, '0, 0, 1, "R3 drive held on oe");
        expect_at(FLT, 0, '0, 0, 0, "R3 float on oe");
        idle(FLT + 3);
        oe_n = 0;
        expect_at(OEC - 1, 0, '0, 0, 1, "R10 not yet valid");
        expect_at(OEC, 1, 16'h00A5, 1, 1, "R10 enable access");
        idle(OEC + 2);

        // Standby
        sel_n = 1;
        expect_at(1, 1, 16'h00A5, 0, 1, "R3 valid drops on select");
        expect_at(FLT, 0, '0, 0, 0, "R3 float on select");
        idle(FLT + 4);

        if (sb.size() != 0) begin
            total++; bad++;
            $display("FAIL R11 pending items actual=%0d expected=0", sb.size());
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule